// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps a table of message-signalled interrupt vectors, and the pending flags for those vectors, inside one 4 KB register page. Software reaches the page through a simple 32-bit slave port. For each vector it programs a 64-bit target address and a 32-bit payload. It can also set a mask on each vector, and there is one mask for the whole function. Device logic raises per-vector requests on `irq_req`. An unmasked request becomes one posted write message on a valid/ready output that carries the address and the payload. A masked request only sets the vector's pending flag. When the vector is later unmasked, the message is sent at that point.

The scheduler is a two-state machine. `S_IDLE` waits for a vector that is pending, unmasked and in use. Transition *launch* (`S_IDLE` to `S_SEND`) captures the lowest-numbered such vector into the output register and clears its pending flag in the same cycle. `S_SEND` holds the message steady. Transition *accept* (`S_SEND` to `S_IDLE`) happens on the cycle where `msg_ready` is high. Every accepted request first goes through the pending array, so a request that arrives while the port is stalled waits there and is not lost.

Top module: `msix_vector_ctrl`

## Requirements
- R1: Vector v occupies 16 bytes at offset 16*v. The words at +0 (low address), +4 (high address) and +8 (payload) read back as written. The word at +12 (control) keeps only bit 0, the mask, and its other bits read as zero.
- R2: The dword at offset 0x800 reports vector v's pending flag at bit v. Writes to it are ignored.
- R3: Only accesses with `bus_be` = 4'b1111 take effect. Any other byte-enable pattern leaves the state unchanged, and a read with such a pattern returns zero. Offsets outside the table and outside the pending dword read zero.
- R4: After reset all address and payload words are zero, every implemented vector's mask bit is set, no flag is pending and `msg_valid` is low.
- R5: A request for a vector whose `vec_used` bit is low is dropped and produces neither a message nor a pending flag.
- R6: A request for a vector that is masked, by its own bit or by `fn_mask`, sets its pending flag and sends no message.
- R7: A request for an unmasked, in-use vector produces exactly one message with address {high, low} and the programmed payload.
- R8: Clearing a pending vector's mask by a table write sends its message exactly once and clears its pending flag.
- R9: When `fn_mask` is lowered, every pending unmasked vector is sent once, with the lowest index first.
- R10: At most one message is held at a time. While `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` stay stable, and requests that arrive meanwhile stay pending and are delivered later.
- R11: Lowering a vector's `vec_used` bit clears its pending flag.
- R12: Read data appears on `bus_rdata` one clock after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the 4 KB page |
| bus_be | input | 4 | Byte enables; only 4'b1111 is honoured |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| fn_mask | input | 1 | Function-wide mask |
| vec_used | input | NUM_VEC | Per-vector in-use flags |
| irq_req | input | NUM_VEC | Per-vector request pulses |
| msg_valid | output | 1 | Message held on the output |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The assertions make three assumptions about the inputs. Reset is high at time zero. Nothing other than the slave port changes the table. `msg_ready` may take any value in any cycle, so holding the message steady during a stall must come from the design itself. The bench drives every input at the falling edge and pulses requests for exactly one cycle. It stalls the output deliberately while requests and repeated requests for the same vector keep arriving. Each expected message goes into a queue before the stimulus that should cause it, and the monitor flags any message it sees when no message is expected.

// File: rtl/msixc_pkg.sv
package msixc_pkg;
    localparam int PAGE_AW = 12;
    localparam logic [PAGE_AW-1:0] PEND_OFS = 12'h800;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_SEND = 1'b1
    } sched_state_t;

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
        logic [31:0] data;
    } vec_entry_t;
endpackage

// File: rtl/msixc_table.sv
module msixc_table
    import msixc_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    input  logic [NUM_VEC-1:0] pend,
    input  logic [VW-1:0]      rd_sel,
    output logic [31:0]        bus_rdata,
    output logic [NUM_VEC-1:0] vmask,
    output vec_entry_t         rd_entry
);
    localparam logic [11:0] TBL_END = 12'(NUM_VEC * 16);

    vec_entry_t          ent [NUM_VEC];
    logic                full, in_tbl, is_pend, wr_en;
    logic [VW-1:0]       vidx;
    logic [1:0]          widx;
    logic [31:0]         rd_val;
    logic                unused_low;

    assign full    = (bus_be == 4'hF);
    assign in_tbl  = (bus_addr < TBL_END);
    assign is_pend = (bus_addr[11:2] == PEND_OFS[11:2]);
    assign vidx    = bus_addr[VW+3:4];
    assign widx    = bus_addr[3:2];
    assign wr_en   = bus_req & bus_we & full & in_tbl;
    assign unused_low = ^bus_addr[1:0];

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[v]   <= '0;
                vmask[v] <= 1'b1;
            end else if (wr_en && vidx == VW'(v)) begin
                unique case (widx)
                    2'd0: ent[v].lo   <= bus_wdata;
                    2'd1: ent[v].hi   <= bus_wdata;
                    2'd2: ent[v].data <= bus_wdata;
                    2'd3: vmask[v]    <= bus_wdata[0];
                endcase
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (in_tbl) begin
            unique case (widx)
                2'd0: rd_val = ent[vidx].lo;
                2'd1: rd_val = ent[vidx].hi;
                2'd2: rd_val = ent[vidx].data;
                2'd3: rd_val = {31'd0, vmask[vidx]};
            endcase
        end else if (is_pend) begin
            rd_val = 32'(pend);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_req && !bus_we)
            bus_rdata <= full ? rd_val : '0;
    end

    assign rd_entry = ent[rd_sel];

    p_partial_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_be != 4'hF) |=> $stable(vmask));

    p_reset_mask_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (&vmask));
endmodule

// File: rtl/msixc_pending.sv
module msixc_pending #(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] irq_req,
    input  logic [NUM_VEC-1:0] vec_used,
    input  logic [NUM_VEC-1:0] clr,
    output logic [NUM_VEC-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= ((pend & ~clr) | irq_req) & vec_used;
    end

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
        p_set_r6: assert property (@(posedge clk) disable iff (rst)
            (irq_req[v] && vec_used[v]) |=> pend[v]);
        p_keep_r10: assert property (@(posedge clk) disable iff (rst)
            (pend[v] && vec_used[v] && !clr[v]) |=> pend[v]);
    end
endmodule

// File: rtl/msixc_sched.sv
module msixc_sched
    import msixc_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] pend,
    input  logic [NUM_VEC-1:0] vmask,
    input  logic               fn_mask,
    input  vec_entry_t         entry,
    output logic [VW-1:0]      sel,
    output logic [NUM_VEC-1:0] clr,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    sched_state_t       state_q, state_n;
    logic [NUM_VEC-1:0] elig;
    logic               launch;

    assign elig = pend & ~vmask & {NUM_VEC{~fn_mask}};

    always_comb begin
        sel = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--)
            if (elig[v]) sel = VW'(v);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        launch  = 1'b0;
        unique case (state_q)
            S_IDLE: if (|elig) begin
                launch  = 1'b1;
                state_n = S_SEND;
            end
            S_SEND: if (msg_ready) state_n = S_IDLE;
        endcase
    end

    always_comb begin
        msg_valid = (state_q == S_SEND);
        clr       = launch ? (NUM_VEC'(1) << sel) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_addr <= '0;
            msg_data <= '0;
        end else if (launch) begin
            msg_addr <= {entry.hi, entry.lo};
            msg_data <= entry.data;
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    p_fn_block_r6: assert property (@(posedge clk) disable iff (rst)
        fn_mask |=> !$rose(msg_valid));
endmodule

// File: rtl/msix_vector_ctrl.sv
module msix_vector_ctrl
    import msixc_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               fn_mask,
    input  logic [NUM_VEC-1:0] vec_used,
    input  logic [NUM_VEC-1:0] irq_req,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    logic [NUM_VEC-1:0] pend, vmask, clr;
    logic [VW-1:0]      sel;
    vec_entry_t         entry;

    msixc_table #(.NUM_VEC(NUM_VEC)) u_table (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .pend(pend), .rd_sel(sel), .bus_rdata(bus_rdata),
        .vmask(vmask), .rd_entry(entry)
    );

    msixc_pending #(.NUM_VEC(NUM_VEC)) u_pending (
        .clk(clk), .rst(rst), .irq_req(irq_req), .vec_used(vec_used),
        .clr(clr), .pend(pend)
    );

    msixc_sched #(.NUM_VEC(NUM_VEC)) u_sched (
        .clk(clk), .rst(rst), .pend(pend), .vmask(vmask), .fn_mask(fn_mask),
        .entry(entry), .sel(sel), .clr(clr), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    p_launch_clears_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> $onehot($past(pend) & ~pend | $past(pend) & ~$past(vec_used))
                             || $onehot($past(pend) & ~pend));
endmodule

// File: tb/test_msix_vector_ctrl.sv
module test_msix_vector_ctrl;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [3:0]    bus_be = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          fn_mask = 1'b0;
    logic [NV-1:0] vec_used = '1;
    logic [NV-1:0] irq_req = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int checks = 0, errors = 0;
    string cur_tag = "R7";
    logic [95:0] exp_q [$];

    always #2.5 clk = ~clk;

    msix_vector_ctrl #(.NUM_VEC(NV)) i_msix_vector_ctrl (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fn_mask(fn_mask), .vec_used(vec_used),
        .irq_req(irq_req), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    function automatic logic [31:0] lo_of(int v);   return 32'h1000_0000 + 32'(v * 16); endfunction
    function automatic logic [31:0] hi_of(int v);   return 32'h0000_00A0 + 32'(v); endfunction
    function automatic logic [31:0] dat_of(int v);  return 32'hD000_0000 + 32'(v); endfunction

    task automatic check(string tag, logic [95:0] got, logic [95:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [3:0] be, logic [31:0] exp);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_req = 1'b0;
        check(tag, 96'(bus_rdata), 96'(exp));
    endtask

    task automatic pulse(logic [NV-1:0] v);
        @(negedge clk); irq_req = v;
        @(negedge clk); irq_req = '0;
    endtask

    task automatic expect_msg(int v);
        exp_q.push_back({hi_of(v), lo_of(v), dat_of(v)});
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(string tag);
        idle(20);
        check(tag, 96'(exp_q.size()), 96'd0);
    endtask

    // scoreboard monitor: a handshake seen at the falling edge completes at the next rising edge
    always @(negedge clk) begin
        if (!rst && msg_valid && msg_ready) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL %s unexpected message got %h expected none", cur_tag, {msg_addr, msg_data});
            end else begin
                check(cur_tag, {msg_addr, msg_data}, exp_q.pop_front());
            end
        end
    end

    initial begin
        int wd = 0;
        while (wd < 20000) begin @(posedge clk); wd++; end
        checks++; errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst = 1'b0;
        // R4 reset state
        check("R4 msg_valid", 96'(msg_valid), 96'd0);
        rd_chk("R4 ctrl v0 mask set", 12'h00C, 4'hF, 32'd1);
        rd_chk("R4 ctrl v7 mask set", 12'h07C, 4'hF, 32'd1);
        rd_chk("R4 low word v3 zero", 12'h030, 4'hF, 32'd0);
        rd_chk("R4 pending zero", 12'h800, 4'hF, 32'd0);

        // R1 program table, read back (R12 one-cycle read latency)
        for (int v = 0; v < NV; v++) begin
            wr(12'(v * 16),     lo_of(v),  4'hF);
            wr(12'(v * 16 + 4), hi_of(v),  4'hF);
            wr(12'(v * 16 + 8), dat_of(v), 4'hF);
        end
        rd_chk("R1 low v2",  12'h020, 4'hF, lo_of(2));
        rd_chk("R1 high v2", 12'h024, 4'hF, hi_of(2));
        rd_chk("R12 data v2", 12'h028, 4'hF, dat_of(2));
        wr(12'h07C, 32'hFFFF_0003, 4'hF);
        rd_chk("R1 ctrl keeps bit0 only", 12'h07C, 4'hF, 32'd1);

        // R3 partial accesses and unmapped offsets
        wr(12'h020, 32'h0000_DEAD, 4'h3);
        rd_chk("R3 partial write ignored", 12'h020, 4'hF, lo_of(2));
        rd_chk("R3 partial read zero", 12'h020, 4'h1, 32'd0);
        wr(12'h00C, 32'd0, 4'h1);
        rd_chk("R3 partial ctrl write ignored", 12'h00C, 4'hF, 32'd1);
        rd_chk("R3 unmapped offset", 12'h900, 4'hF, 32'd0);

        // R6 masked vector request pends
        cur_tag = "R6 masked request";
        pulse(8'h02);
        idle(5);
        rd_chk("R6 pending v1", 12'h800, 4'hF, 32'h02);

        // R8 unmask by table write replays once
        cur_tag = "R8 replay";
        expect_msg(1);
        wr(12'h01C, 32'd0, 4'hF);
        drain("R8 replay delivered once");
        rd_chk("R8 pending cleared", 12'h800, 4'hF, 32'd0);

        // R7 unmasked request
        wr(12'h00C, 32'd0, 4'hF);
        wr(12'h02C, 32'd0, 4'hF);
        wr(12'h03C, 32'd0, 4'hF);
        cur_tag = "R7 direct send";
        expect_msg(2);
        pulse(8'h04);
        drain("R7 one message");

        // R6/R9 function mask
        cur_tag = "R6 function mask";
        fn_mask = 1'b1;
        pulse(8'h09);
        idle(5);
        rd_chk("R6 pending under function mask", 12'h800, 4'hF, 32'h09);
        cur_tag = "R9 function unmask order";
        expect_msg(0);
        expect_msg(3);
        @(negedge clk); fn_mask = 1'b0;
        drain("R9 both replayed");
        rd_chk("R9 pending cleared", 12'h800, 4'hF, 32'd0);

        // R5 unused vector dropped
        cur_tag = "R5 unused dropped";
        vec_used = 8'hEF;
        wr(12'h04C, 32'd0, 4'hF);
        pulse(8'h10);
        idle(5);
        rd_chk("R5 no pending for unused", 12'h800, 4'hF, 32'd0);
        drain("R5 no message");

        // R11 unuse clears pending
        cur_tag = "R11 unuse";
        pulse(8'h20);
        idle(2);
        rd_chk("R11 pending before unuse", 12'h800, 4'hF, 32'h20);
        vec_used = 8'hCF;
        idle(2);
        rd_chk("R11 pending cleared", 12'h800, 4'hF, 32'd0);
        vec_used = 8'hFF;
        drain("R11 no message");

        // R10 stall
        cur_tag = "R10 stall";
        msg_ready = 1'b0;
        wr(12'h05C, 32'd0, 4'hF);
        wr(12'h06C, 32'd0, 4'hF);
        pulse(8'h61);
        idle(2);
        check("R10 valid held", 96'(msg_valid), 96'd1);
        check("R10 first message v0", {msg_addr, msg_data}, {hi_of(0), lo_of(0), dat_of(0)});
        pulse(8'h01);
        idle(6);
        check("R10 still held", {msg_valid, msg_addr, msg_data}, {1'b1, hi_of(0), lo_of(0), dat_of(0)});
        rd_chk("R10 queued requests pending", 12'h800, 4'hF, 32'h61);
        expect_msg(0);
        expect_msg(0);
        expect_msg(5);
        expect_msg(6);
        @(negedge clk); msg_ready = 1'b1;
        drain("R10 all delivered");

        // R2 pending dword read-only
        cur_tag = "R2 pending write";
        wr(12'h800, 32'hFF, 4'hF);
        rd_chk("R2 write ignored", 12'h800, 4'hF, 32'd0);
        drain("R2 no message");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule